// File: doc/BRIEF.md
# Serial Register Link Master

This block runs transfers on a slow three-wire serial link to a small remote register file, so that software does not have to toggle the wires itself. The link has an enable line, a clock line and a data-out line driven by this block, and a data-return line driven by the remote side. The remote side also provides a ready flag and accepts a reset pulse from this block.

A host hands over one request at a time. A request is either a write, which carries a 3-bit register address and a 32-bit value, or a read, which carries only the address. Before each transfer the block holds all three link outputs low and polls the ready flag. If the flag stays low for too long, the block pulses the remote reset and polls again. After the third reset pulse it gives up and reports a timeout. Once ready is seen, it shifts the frame out. A write sends its data first and its address second. A read sends its address and then clocks 32 bits back in. Both frame types end with a direction bit, which is sent with enable low.

The request port is valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. While the block is busy, `req_ready` stays low and the request fields are not looked at. The response has no back-pressure: `rsp_valid` is a single-cycle pulse, and `rsp_timeout` and `rsp_rdata` are valid during that cycle.

Top module: `srb_master`

## Requirements
- R1: After reset and whenever the block is idle, `link_en`, `link_clk`, `link_dout` and `remote_rst` are low, `busy` is low and `req_ready` is high.
- R2: A request is taken when `req_valid` and `req_ready` are both high. `busy` is high from the next cycle through the cycle of `rsp_valid`. While busy, `req_ready` is low, and any request presented has no effect on the link or on the remote registers.
- R3: `remote_ready` is first sampled in the cycle after acceptance, and then once every `POLL_CYC` cycles. All link outputs stay low while polling.
- R4: After `POLL_LIMIT` samples in a row find `remote_ready` low, `remote_rst` is held high for `RST_CYC` cycles and polling starts again. When the third such pulse ends, the transfer finishes with `rsp_timeout` = 1 and there is no activity on enable, clock or data. A write that times out leaves the remote register unchanged.
- R5: Every bit slot lasts 2*`HALF_CYC`+1 cycles. `link_dout` and `link_en` change only at the start of a slot. `link_clk` is low for cycles `HALF_CYC` to 2*`HALF_CYC`-1 of the slot and high in the last cycle. Its rising edge is the capture point, and data is stable on both clock edges.
- R6: A write frame begins with `link_en` high. It shifts the 32 data bits MSB first, then the 3 address bits MSB first.
- R7: A read frame begins with `link_en` high and shifts the 3 address bits MSB first. It sends no data bits.
- R8: After the address comes a direction slot. In this slot `link_en` goes low while `link_clk` is high, and `link_dout` carries 1 for a write or 0 for a read. `link_dout` returns low at the end of the slot.
- R9: A read then runs 32 more slots with `link_en` and `link_dout` low. `link_din` is sampled in the hold cycle after each clock rise, and the first bit sampled is the MSB of `rsp_rdata`.
- R10: `rsp_valid` is high for exactly one cycle. That cycle comes right after the final slot (or right after the last reset pulse on a timeout). In the next cycle `busy` is low and all link outputs are low.
- R11: A value written to any of the 8 addresses is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Remote register address |
| req_wdata | input | DATA_W | Write value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Transfer abandoned, remote never ready |
| rsp_rdata | output | DATA_W | Read result |
| busy | output | 1 | Transfer in progress |
| link_en | output | 1 | Link enable line |
| link_clk | output | 1 | Link clock line |
| link_dout | output | 1 | Link data towards remote |
| link_din | input | 1 | Link data returned by remote |
| remote_ready | input | 1 | Remote side ready flag |
| remote_rst | output | 1 | Reset pulse to remote side |

## Verification
An error in the slot phase counter appears on `link_clk` within one slot, as a half-period of the wrong length or a rise in the wrong cycle. An error in the shift register or its bit count appears on `link_dout`, or as a direction slot that starts at the wrong point, within the same frame. Errors in the poll or retry counters show up at once as a wrong `remote_rst` width or count, or as a timeout reported after the wrong number of attempts. Any damage to returned bits is caught when the round-trip read completes.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_SEND,
    ST_DIR,
    ST_RECV,
    ST_FIN
  } srb_state_e;
endpackage

// File: rtl/srb_slot_timer.sv
// Phase counter for one bit slot: HALF_CYC cycles, then clock low for
// HALF_CYC cycles, then one hold cycle with the clock high.
module srb_slot_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fall_go,
  output logic rise_go,
  output logic slot_end
);
  localparam int SLOT_LEN = 2 * HALF_CYC + 1;
  localparam int PW       = $clog2(SLOT_LEN + 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run) begin
      phase_q <= '0;
    end else if (phase_q == PW'(SLOT_LEN - 1)) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign fall_go  = run && (phase_q == PW'(HALF_CYC - 1));
  assign rise_go  = run && (phase_q == PW'(2 * HALF_CYC - 1));
  assign slot_end = run && (phase_q == PW'(SLOT_LEN - 1));
endmodule

// File: rtl/srb_ready_poller.sv
// Polls the remote ready flag at a fixed interval, pulses the remote reset
// after a run of failed polls, and gives up after TRIES reset pulses.
module srb_ready_poller #(
  parameter int POLL_CYC   = 16,
  parameter int POLL_LIMIT = 64,
  parameter int RST_CYC    = 8,
  parameter int TRIES      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic remote_ready,
  output logic found,
  output logic exhausted,
  output logic remote_rst
);
  localparam int PLW = $clog2(POLL_LIMIT + 1);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam int TRW = $clog2(TRIES + 1);

  logic           in_rst_q;
  logic [PLW-1:0] polls_q;
  logic [RCW-1:0] rcnt_q;
  logic [TRW-1:0] tries_q;
  logic           at_poll;
  logic           polling;
  logic           fail_now;
  logic           last_fail;
  logic           rst_done;

  assign polling   = active && !in_rst_q;
  assign fail_now  = polling && at_poll && !remote_ready;
  assign last_fail = fail_now && (polls_q == PLW'(POLL_LIMIT - 1));
  assign rst_done  = active && in_rst_q && (rcnt_q == RCW'(RST_CYC - 1));

  // Interval counter: only needed when polls are more than one cycle apart.
  generate
    if (POLL_CYC > 1) begin : g_tick
      localparam int TW = $clog2(POLL_CYC);
      logic [TW-1:0] tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tick_q <= '0;
        end else if (start || !polling) begin
          tick_q <= '0;
        end else if ((fail_now && !last_fail) || (tick_q != '0)) begin
          tick_q <= (tick_q == TW'(POLL_CYC - 1)) ? '0 : tick_q + 1'b1;
        end
      end
      assign at_poll = (tick_q == '0);
    end else begin : g_notick
      assign at_poll = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rst_q <= 1'b0;
      polls_q  <= '0;
      rcnt_q   <= '0;
      tries_q  <= '0;
    end else if (start) begin
      in_rst_q <= 1'b0;
      polls_q  <= '0;
      rcnt_q   <= '0;
      tries_q  <= '0;
    end else if (active) begin
      if (in_rst_q) begin
        if (rst_done) begin
          in_rst_q <= 1'b0;
          rcnt_q   <= '0;
          tries_q  <= tries_q + 1'b1;
        end else begin
          rcnt_q <= rcnt_q + 1'b1;
        end
      end else if (last_fail) begin
        in_rst_q <= 1'b1;
        polls_q  <= '0;
      end else if (fail_now) begin
        polls_q <= polls_q + 1'b1;
      end
    end
  end

  assign found      = polling && at_poll && remote_ready;
  assign exhausted  = rst_done && (tries_q == TRW'(TRIES - 1));
  assign remote_rst = active && in_rst_q;
endmodule

// File: rtl/srb_frame_shifter.sv
// Outgoing frame shift register (MSB first) and incoming capture register.
module srb_frame_shifter #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_write,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  input  logic              capture,
  input  logic              din,
  output logic              cur_bit,
  output logic              next_bit,
  output logic              tx_last,
  output logic              rx_last,
  output logic [DATA_W-1:0] rx_data
);
  localparam int FW  = DATA_W + ADDR_W;
  localparam int CW  = $clog2(FW + 1);
  localparam int RXW = $clog2(DATA_W + 1);

  logic [FW-1:0]     tx_sr_q;
  logic [CW-1:0]     tx_cnt_q;
  logic [DATA_W-1:0] rx_sr_q;
  logic [RXW-1:0]    rx_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr_q  <= '0;
      tx_cnt_q <= '0;
      rx_sr_q  <= '0;
      rx_cnt_q <= '0;
    end else if (load) begin
      // A write frame is data then address; a read frame is the address
      // alone, left-aligned so that the MSB leaves first in both cases.
      tx_sr_q  <= load_write ? {load_data, load_addr} : {load_addr, {DATA_W{1'b0}}};
      tx_cnt_q <= load_write ? CW'(FW) : CW'(ADDR_W);
      rx_sr_q  <= '0;
      rx_cnt_q <= RXW'(DATA_W);
    end else begin
      if (shift) begin
        tx_sr_q  <= {tx_sr_q[FW-2:0], 1'b0};
        tx_cnt_q <= tx_cnt_q - 1'b1;
      end
      if (capture) begin
        rx_sr_q  <= {rx_sr_q[DATA_W-2:0], din};
        rx_cnt_q <= rx_cnt_q - 1'b1;
      end
    end
  end

  assign cur_bit  = tx_sr_q[FW-1];
  assign next_bit = tx_sr_q[FW-2];
  assign tx_last  = (tx_cnt_q == CW'(1));
  assign rx_last  = (rx_cnt_q == RXW'(1));
  assign rx_data  = rx_sr_q;
endmodule

// File: rtl/srb_master.sv
module srb_master
  import srb_pkg::*;
#(
  parameter int HALF_CYC   = 4,
  parameter int POLL_CYC   = 16,
  parameter int POLL_LIMIT = 64,
  parameter int RST_CYC    = 8,
  parameter int TRIES      = 3,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_timeout,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              link_en,
  output logic              link_clk,
  output logic              link_dout,
  input  logic              link_din,
  input  logic              remote_ready,
  output logic              remote_rst
);
  srb_state_e state_q;
  logic       en_q, clk_q, dout_q, wr_q, to_q;
  logic       accept, in_frame;
  logic       fall_go, rise_go, slot_end;
  logic       found, exhausted;
  logic       cur_bit, next_bit, tx_last, rx_last;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_frame  = (state_q == ST_SEND) || (state_q == ST_DIR) || (state_q == ST_RECV);

  srb_slot_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (in_frame),
    .fall_go  (fall_go),
    .rise_go  (rise_go),
    .slot_end (slot_end)
  );

  srb_ready_poller #(
    .POLL_CYC   (POLL_CYC),
    .POLL_LIMIT (POLL_LIMIT),
    .RST_CYC    (RST_CYC),
    .TRIES      (TRIES)
  ) u_poller (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .active       (state_q == ST_POLL),
    .remote_ready (remote_ready),
    .found        (found),
    .exhausted    (exhausted),
    .remote_rst   (remote_rst)
  );

  srb_frame_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_write (req_write),
    .load_addr  (req_addr),
    .load_data  (req_wdata),
    .shift      ((state_q == ST_SEND) && slot_end),
    .capture    ((state_q == ST_RECV) && slot_end),
    .din        (link_din),
    .cur_bit    (cur_bit),
    .next_bit   (next_bit),
    .tx_last    (tx_last),
    .rx_last    (rx_last),
    .rx_data    (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      clk_q   <= 1'b0;
      dout_q  <= 1'b0;
      wr_q    <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_POLL;
            wr_q    <= req_write;
            to_q    <= 1'b0;
          end
        end
        ST_POLL: begin
          if (found) begin
            state_q <= ST_SEND;
            en_q    <= 1'b1;
            dout_q  <= cur_bit;
          end else if (exhausted) begin
            state_q <= ST_FIN;
            to_q    <= 1'b1;
          end
        end
        ST_SEND, ST_DIR, ST_RECV: begin
          if (fall_go) clk_q <= 1'b0;
          if (rise_go) clk_q <= 1'b1;
          if (slot_end) begin
            case (state_q)
              ST_SEND: begin
                if (tx_last) begin
                  state_q <= ST_DIR;
                  en_q    <= 1'b0;
                  dout_q  <= wr_q;
                end else begin
                  dout_q <= next_bit;
                end
              end
              ST_DIR: begin
                dout_q  <= 1'b0;
                state_q <= wr_q ? ST_FIN : ST_RECV;
              end
              default: begin
                if (rx_last) state_q <= ST_FIN;
              end
            endcase
          end
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          en_q    <= 1'b0;
          clk_q   <= 1'b0;
          dout_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign rsp_valid   = (state_q == ST_FIN);
  assign rsp_timeout = to_q;
  assign link_en     = en_q;
  assign link_clk    = clk_q;
  assign link_dout   = dout_q;
endmodule

// File: rtl/srb_master_chk.sv
module srb_master_chk
  import srb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       busy,
  input logic       rsp_valid,
  input logic       link_en,
  input logic       link_clk,
  input logic       link_dout,
  input logic       remote_rst,
  input srb_state_e state
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!link_en && !link_clk && !link_dout && !remote_rst));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  assert_poll_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL) |-> (!link_en && !link_clk && !link_dout));

  assert_rst_in_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    remote_rst |-> (busy && !link_en && !link_clk));

  assert_rise_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_clk) |-> ($stable(link_dout) && $stable(link_en)));

  assert_fall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_clk) |-> ($stable(link_dout) && $stable(link_en)));

  assert_en_drop_clk_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_en) |-> link_clk);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && !busy));
endmodule

bind srb_master srb_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .link_en    (link_en),
  .link_clk   (link_clk),
  .link_dout  (link_dout),
  .remote_rst (remote_rst),
  .state      (state_q)
);

// File: tb/sim_srb_master.sv
`timescale 1ns/1ps
module sim_srb_master;
  localparam int H  = 2;
  localparam int PC = 3;
  localparam int PL = 4;
  localparam int RC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_timeout, busy;
  logic [31:0] rsp_rdata;
  logic        link_en, link_clk, link_dout, remote_rst;
  logic        link_din = 1'b0;
  logic        remote_ready = 1'b1;

  always #10 clk = ~clk;

  srb_master #(.HALF_CYC(H), .POLL_CYC(PC), .POLL_LIMIT(PL), .RST_CYC(RC),
               .TRIES(3), .DATA_W(32), .ADDR_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
    .busy(busy), .link_en(link_en), .link_clk(link_clk), .link_dout(link_dout),
    .link_din(link_din), .remote_ready(remote_ready), .remote_rst(remote_rst));

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    case (a)
      0: pat = 32'h0000_0000;
      1: pat = 32'hFFFF_FFFF;
      2: pat = 32'hA5A5_5A5A;
      3: pat = 32'h8000_0001;
      default: pat = 32'h1234_5678 * (a + 1) + a;
    endcase
  endfunction

  // Behavioural remote register file.
  logic [31:0] rmem [8];
  logic [34:0] r_sr;
  int          r_cnt, r_idx, r_mode;
  logic [2:0]  r_addr;
  int          rst_pulses = 0;

  initial begin
    for (int i = 0; i < 8; i++) rmem[i] = '0;
    r_sr = '0; r_cnt = 0; r_idx = 0; r_mode = 0; r_addr = '0;
  end

  always @(posedge remote_rst) rst_pulses++;

  always @(posedge link_en) begin
    r_cnt = 0; r_sr = '0; r_mode = 0;
  end

  always @(posedge link_clk) begin
    if (link_en) begin
      r_sr = {r_sr[33:0], link_dout};
      r_cnt++;
    end else if (r_mode == 0) begin
      if (link_dout) begin
        if (r_cnt == 35) rmem[r_sr[2:0]] = r_sr[34:3];
        r_mode = 2;
      end else begin
        r_addr = r_sr[2:0];
        r_idx  = 0;
        r_mode = 1;
      end
    end else if (r_mode == 1 && r_idx < 32) begin
      link_din <= rmem[r_addr][31 - r_idx];
      r_idx++;
    end
  end

  // Cycle-level reference model of the expected outputs.
  logic        exp_en = 0, exp_clk = 0, exp_dout = 0, exp_rst = 0;
  logic        exp_busy = 0, exp_rv = 0, exp_to = 0, exp_rd_chk = 0;
  logic [31:0] exp_rd = '0;
  string       ph = "R1";
  logic [31:0] mdl_mem [8];
  bit          mdl_known [8];

  task automatic slot_wait();
    repeat (H) @(posedge clk);
    exp_clk = 1'b0;
    repeat (H) @(posedge clk);
    exp_clk = 1'b1;
    @(posedge clk);
  endtask

  task automatic m_run();
    bit          w = req_write;
    logic [2:0]  a = req_addr;
    logic [31:0] d = req_wdata;
    int          tries = 0;
    bit          got = 0;
    bit          bq[$];
    exp_busy = 1'b1;
    while (!got && tries < 3) begin
      int polls = 0;
      ph = "R3";
      while (1) begin
        @(posedge clk);
        if (remote_ready) begin got = 1; break; end
        polls++;
        if (polls == PL) break;
        repeat (PC - 1) @(posedge clk);
      end
      if (!got) begin
        ph = "R4";
        exp_rst = 1'b1;
        repeat (RC) @(posedge clk);
        exp_rst = 1'b0;
        tries++;
      end
    end
    if (got) begin
      if (w) for (int i = 31; i >= 0; i--) bq.push_back(d[i]);
      for (int i = 2; i >= 0; i--) bq.push_back(a[i]);
      ph = w ? "R6" : "R7";
      exp_en = 1'b1;
      exp_dout = bq[0];
      for (int k = 0; k < bq.size(); k++) begin
        slot_wait();
        if (k < bq.size() - 1) exp_dout = bq[k + 1];
        else begin exp_en = 1'b0; exp_dout = w; ph = "R8"; end
      end
      slot_wait();
      exp_dout = 1'b0;
      if (!w) begin
        ph = "R9";
        repeat (32) slot_wait();
      end
    end
    ph = "R10";
    exp_rv = 1'b1;
    exp_to = !got;
    exp_rd_chk = got && !w && mdl_known[a];
    exp_rd = mdl_mem[a];
    if (got && w) begin mdl_mem[a] = d; mdl_known[a] = 1; end
    @(posedge clk);
    exp_rv = 0; exp_busy = 0; exp_clk = 0; exp_en = 0; exp_dout = 0; exp_rd_chk = 0;
    ph = "R1";
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mdl_mem[i] = '0; mdl_known[i] = 0; end
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (req_valid && !exp_busy) m_run();
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(link_en === exp_en,     ph,    "link_en",    link_en,    exp_en);
      chk(link_dout === exp_dout, ph,    "link_dout",  link_dout,  exp_dout);
      chk(link_clk === exp_clk,   "R5",  "link_clk",   link_clk,   exp_clk);
      chk(remote_rst === exp_rst, "R4",  "remote_rst", remote_rst, exp_rst);
      chk(busy === exp_busy,      "R2",  "busy",       busy,       exp_busy);
      chk(req_ready === !exp_busy,"R2",  "req_ready",  req_ready,  !exp_busy);
      chk(rsp_valid === exp_rv,   "R10", "rsp_valid",  rsp_valid,  exp_rv);
      if (exp_rv) begin
        chk(rsp_timeout === exp_to, "R4", "rsp_timeout", rsp_timeout, exp_to);
        if (exp_rd_chk) chk(rsp_rdata === exp_rd, "R9", "rsp_rdata", rsp_rdata, exp_rd);
      end
    end
  end

  task automatic xfer(input bit w, input logic [2:0] a, input logic [31:0] d,
                      output bit to, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b1, "R2", "busy after accept", busy, 1);
    while (rsp_valid !== 1'b1) @(negedge clk);
    to = rsp_timeout;
    rd = rsp_rdata;
    @(negedge clk);
    chk(busy === 0 && link_clk === 0 && link_en === 0, "R10", "idle after response",
        {busy, link_clk, link_en}, 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    bit          to;
    logic [31:0] rd;
    int          p0;
    repeat (5) @(negedge clk);
    chk(link_en === 0 && link_clk === 0 && link_dout === 0 && remote_rst === 0,
        "R1", "lines in reset", {link_en, link_clk, link_dout, remote_rst}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1 && busy === 0 && rsp_valid === 0, "R1", "idle after reset",
        {req_ready, busy, rsp_valid}, 3'b100);

    // R6 / R11: write all addresses, then read back in reverse.
    for (int a = 0; a < 8; a++) begin
      xfer(1, 3'(a), pat(a), to, rd);
      chk(to === 0, "R6", "write no timeout", to, 0);
    end
    for (int a = 7; a >= 0; a--) begin
      xfer(0, 3'(a), 32'h0, to, rd);
      chk(rd === pat(a), "R11", "round trip", rd, pat(a));
    end

    // R3: ready arrives late, no reset pulse.
    p0 = rst_pulses;
    remote_ready = 0;
    fork
      xfer(1, 3'd4, 32'hCAFE_0004, to, rd);
      begin repeat (8) @(negedge clk); remote_ready = 1; end
    join
    chk(rst_pulses == p0, "R3", "no reset on late ready", rst_pulses - p0, 0);
    xfer(0, 3'd4, 32'h0, to, rd);
    chk(rd === 32'hCAFE_0004, "R11", "late-ready write", rd, 32'hCAFE_0004);

    // R4: one failed attempt then success.
    p0 = rst_pulses;
    remote_ready = 0;
    fork
      xfer(1, 3'd5, 32'h0BAD_F00D, to, rd);
      begin @(negedge remote_rst); repeat (2) @(negedge clk); remote_ready = 1; end
    join
    chk(rst_pulses - p0 == 1, "R4", "one reset pulse", rst_pulses - p0, 1);
    chk(to === 0, "R4", "retry succeeds", to, 0);
    xfer(0, 3'd5, 32'h0, to, rd);
    chk(rd === 32'h0BAD_F00D, "R4", "retry write lands", rd, 32'h0BAD_F00D);

    // R4: never ready, times out after three pulses, write has no effect.
    p0 = rst_pulses;
    remote_ready = 0;
    xfer(1, 3'd2, 32'hDEAD_BEEF, to, rd);
    chk(to === 1, "R4", "timeout flag", to, 1);
    chk(rst_pulses - p0 == 3, "R4", "three reset pulses", rst_pulses - p0, 3);
    remote_ready = 1;
    xfer(0, 3'd2, 32'h0, to, rd);
    chk(rd === pat(2), "R4", "timed-out write ignored", rd, pat(2));

    // R2: request presented while busy is ignored.
    fork
      xfer(1, 3'd6, 32'h6666_0006, to, rd);
      begin
        repeat (20) @(negedge clk);
        chk(req_ready === 0, "R2", "not ready while busy", req_ready, 0);
        req_valid = 1; req_write = 1; req_addr = 3'd7; req_wdata = 32'hBAD0_BAD0;
        @(negedge clk);
        req_valid = 0; req_addr = 3'd6; req_wdata = 32'h6666_0006;
      end
    join
    xfer(0, 3'd7, 32'h0, to, rd);
    chk(rd === pat(7), "R2", "busy request ignored", rd, pat(7));
    xfer(0, 3'd6, 32'h0, to, rd);
    chk(rd === 32'h6666_0006, "R11", "addr 6 updated", rd, 32'h6666_0006);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule